// File: doc/BRIEF.md
# Light Threshold Window Alarm

This block watches a stream of 16-bit light readings. Each reading arrives with a one-cycle done strobe. The block compares it against a window whose two edges are programmed as single bytes. Each byte sets the upper eight bits of its edge, and the lower eight bits of that edge are zero. A reading above the upper edge or below the lower edge counts as a miss.

The block counts misses that arrive back to back. When that count reaches the run length picked by a two-bit persistence code, a sticky alarm flag is set. The flag also drives an open-drain pull-down enable, so the board-level interrupt line is pulled low while the alarm is held. Only a clear pulse from the host lowers the flag. The converter that produces the readings and the bus logic that holds the settings sit outside this block.

Top module: `lux_window_alarm`

## Requirements
- R1: The upper edge is {hi_thr, 8'h00} and the lower edge is {lo_thr, 8'h00}. The low byte of each edge is always zero.
- R2: A reading is a miss when it is strictly greater than the upper edge or strictly less than the lower edge. A reading equal to either edge is inside the window.
- R3: persist_sel chooses the run length of consecutive misses that sets the alarm: 0 needs 1, 1 needs 4, 2 needs 8 and 3 needs 16. The flag rises in the cycle after the strobe of the reading that completes the run.
- R4: A reading inside the window, taken on a strobe, sets the consecutive-miss count back to zero.
- R5: The consecutive-miss count saturates at 16 and does not wrap. After a long run of misses, the next miss after a clear sets the flag again at once.
- R6: The flag stays at 1 until clr_pulse is high at a clock edge. It then reads 0 from the next cycle, provided no new trigger occurs in that same cycle.
- R7: When a trigger and clr_pulse occur in the same cycle, the trigger wins and the flag stays at 1.
- R8: int_pd_en (1 = pull the line low) is 1 exactly when the flag is 1.
- R9: While core_en is 0, the consecutive-miss count is held at zero and strobed readings are ignored.
- R10: A reading is compared only in a cycle where res_done is 1. Data that changes without a strobe has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_en | input | 1 | Converter core enabled |
| res_done | input | 1 | One-cycle strobe: new reading valid |
| res_data | input | 16 | Light reading |
| hi_thr | input | 8 | Upper window edge, high byte |
| lo_thr | input | 8 | Lower window edge, high byte |
| persist_sel | input | 2 | Run-length code for the alarm |
| clr_pulse | input | 1 | Host command that clears the alarm |
| alarm_flag | output | 1 | Sticky alarm status |
| int_pd_en | output | 1 | Open-drain pull-down enable for the interrupt line |

## Verification
The run counter is the only hidden state, so any fault in it shows up as the flag rising one or more readings too early or too late. A counter that fails to reset on an in-window reading or on disable, or one that wraps, makes the flag rise at the wrong strobe. Such a fault is visible in the cycle after the strobe that should, or should not, have completed the run. The bench therefore checks the flag after every reading, across every persistence code and a dense sweep of reading values around both window edges.

// File: rtl/lux_window_alarm.sv
module lux_window_alarm #(
  parameter int DW = 16,
  parameter int TW = 8,
  parameter int MAX_RUN = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          core_en,
  input  logic          res_done,
  input  logic [DW-1:0] res_data,
  input  logic [TW-1:0] hi_thr,
  input  logic [TW-1:0] lo_thr,
  input  logic [1:0]    persist_sel,
  input  logic          clr_pulse,
  output logic          alarm_flag,
  output logic          int_pd_en
);
  localparam int CW = $clog2(MAX_RUN) + 1;
  localparam logic [CW-1:0] SAT = CW'(MAX_RUN);

  logic [DW-1:0] hi_edge, lo_edge;
  logic          miss, hit, trigger;
  logic [CW-1:0] run_cnt, run_inc, need;

  assign hi_edge = {hi_thr, {(DW-TW){1'b0}}};
  assign lo_edge = {lo_thr, {(DW-TW){1'b0}}};
  assign miss    = (res_data > hi_edge) || (res_data < lo_edge);
  assign hit     = res_done && core_en;
  assign run_inc = (run_cnt == SAT) ? SAT : run_cnt + 1'b1;

  always_comb begin
    case (persist_sel)
      2'd0:    need = CW'(1);
      2'd1:    need = CW'(4);
      2'd2:    need = CW'(8);
      default: need = CW'(MAX_RUN);
    endcase
  end

  assign trigger = hit && miss && (run_inc >= need);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        run_cnt <= '0;
    else if (!core_en) run_cnt <= '0;
    else if (res_done) run_cnt <= miss ? run_inc : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         alarm_flag <= 1'b0;
    else if (trigger)   alarm_flag <= 1'b1;
    else if (clr_pulse) alarm_flag <= 1'b0;
  end

  assign int_pd_en = alarm_flag;

  p_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt <= SAT);
  p_inwin_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !miss) |=> (run_cnt == '0));
  p_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !core_en |=> (run_cnt == '0));
  p_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && miss && persist_sel == 2'd0) |=> alarm_flag);
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_pulse && !res_done) |=> !alarm_flag);
  p_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_flag) |-> $past(res_done && core_en));
  p_pin_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_flag) |-> int_pd_en);
endmodule

// File: tb/lux_window_alarm_tb.sv
module lux_window_alarm_tb;
  localparam int CLK_NS = 10;
  logic clk = 1'b0, rst_n = 1'b0, core_en = 1'b1, res_done = 1'b0, clr_pulse = 1'b0;
  logic [15:0] res_data = '0;
  logic [7:0] hi_thr = 8'h40, lo_thr = 8'h10;
  logic [1:0] persist_sel = 2'd0;
  logic alarm_flag, int_pd_en;
  int checks = 0, fails = 0;

  always #(CLK_NS/2) clk = ~clk;

  lux_window_alarm u_dut (
    .clk(clk), .rst_n(rst_n), .core_en(core_en), .res_done(res_done),
    .res_data(res_data), .hi_thr(hi_thr), .lo_thr(lo_thr),
    .persist_sel(persist_sel), .clr_pulse(clr_pulse),
    .alarm_flag(alarm_flag), .int_pd_en(int_pd_en));

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] v);
    @(negedge clk); res_data = v; res_done = 1'b1;
    @(negedge clk); res_done = 1'b0;
  endtask

  task automatic clear();
    @(negedge clk); clr_pulse = 1'b1;
    @(negedge clk); clr_pulse = 1'b0;
  endtask

  function automatic int run_need(input int code);
    return (code == 0) ? 1 : (4 << (code - 1));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(alarm_flag, 1'b0, "reset flag");
    chk(int_pd_en, 1'b0, "reset R8");
    rst_n = 1'b1;

    // R2 sweep, code 0, window 0x1000..0x4000
    for (int v = 0; v <= 32'hFFFF; v += 255) begin
      logic e;
      clear();
      e = (v > 16'h4000) || (v < 16'h1000);
      send(16'(v));
      chk(alarm_flag, e, "R2 sweep");
      chk(int_pd_en, e, "R8 pin");
    end
    clear(); send(16'h4000); chk(alarm_flag, 1'b0, "R2 equal hi");
    send(16'h1000); chk(alarm_flag, 1'b0, "R2 equal lo");
    send(16'h4001); chk(alarm_flag, 1'b1, "R2 above");
    clear(); send(16'h0FFF); chk(alarm_flag, 1'b1, "R2 below");

    // R1 low byte zero
    hi_thr = 8'h12; lo_thr = 8'h00;
    clear(); send(16'h1200); chk(alarm_flag, 1'b0, "R1 hi edge");
    send(16'h1201); chk(alarm_flag, 1'b1, "R1 hi edge+1");
    hi_thr = 8'hFF; lo_thr = 8'h12;
    clear(); send(16'h1200); chk(alarm_flag, 1'b0, "R1 lo edge");
    send(16'h11FF); chk(alarm_flag, 1'b1, "R1 lo edge-1");
    hi_thr = 8'h40; lo_thr = 8'h10;

    // R3 run length per code
    for (int c = 0; c < 4; c++) begin
      persist_sel = 2'(c);
      send(16'h2000); clear();
      for (int i = 1; i <= 18; i++) begin
        send(16'hF000);
        chk(alarm_flag, i >= run_need(c), "R3 run");
      end
    end

    // R5 saturation: long run, clear, one more miss
    persist_sel = 2'd3; send(16'h2000); clear();
    for (int i = 0; i < 40; i++) send(16'hF000);
    clear(); chk(alarm_flag, 1'b0, "R6 cleared");
    send(16'hF000); chk(alarm_flag, 1'b1, "R5 saturate");

    // R4 in-window resets
    persist_sel = 2'd1; send(16'h2000); clear();
    for (int i = 0; i < 3; i++) send(16'hF000);
    send(16'h2000);
    for (int i = 0; i < 3; i++) send(16'hF000);
    chk(alarm_flag, 1'b0, "R4 reset count");
    send(16'hF000); chk(alarm_flag, 1'b1, "R4 run after reset");

    // R6 sticky across in-window readings
    for (int i = 0; i < 5; i++) send(16'h2000);
    chk(alarm_flag, 1'b1, "R6 sticky");
    clear(); chk(int_pd_en, 1'b0, "R8 release");

    // R9 disable
    send(16'h2000);
    for (int i = 0; i < 3; i++) send(16'hF000);
    @(negedge clk); core_en = 1'b0;
    send(16'hF000); chk(alarm_flag, 1'b0, "R9 ignored when off");
    @(negedge clk); core_en = 1'b1;
    send(16'hF000); chk(alarm_flag, 1'b0, "R9 count zeroed");
    for (int i = 0; i < 3; i++) send(16'hF000);
    chk(alarm_flag, 1'b1, "R9 full run after enable");

    // R7 trigger beats clear
    persist_sel = 2'd0; clear();
    @(negedge clk); res_data = 16'hF000; res_done = 1'b1; clr_pulse = 1'b1;
    @(negedge clk); res_done = 1'b0; clr_pulse = 1'b0;
    chk(alarm_flag, 1'b1, "R7 trigger wins");

    // R10 no strobe
    clear();
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); res_data = 16'hFF00 + 16'(i);
    end
    @(negedge clk);
    chk(alarm_flag, 1'b0, "R10 no strobe");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule